// File: doc/BRIEF.md
# Boundary Register Chain with Two-Stage Cells

This block is a chain of boundary cells. Each cell sits in the path between a pin and the core logic, or between the core logic and a pin. A cell holds two flops. The first flop, the capture/shift stage, either samples the cell's parallel input or takes the bit shifted along from the previous cell. The second flop, the update stage, is the value that is driven toward the far side of the cell when test routing is selected.

Because the two stages are separate, a new test pattern can be shifted through the whole chain while each pin keeps driving the pattern that was applied before. The new pattern replaces the old one only when the update strobe fires.

All cells share the control inputs, which a test access controller outside this block drives directly. Both strobes act as clock enables on the one functional clock. The cell count is a parameter. Cell 0 is the cell nearest the serial input, and the serial output is taken from the capture stage of the last cell.

Top module: `bsc_chain`

## Requirements
- R1: After an active-low reset, every capture stage and every update stage holds 0. With test routing selected, `par_out` therefore reads 0 and `ser_out` reads 0.
- R2: On a clock edge where `cap_en`=1 and `shift_sel`=0, every cell's capture stage loads its own bit of `par_in`.
- R3: On a clock edge where `cap_en`=1 and `shift_sel`=1, the capture stages shift. Cell 0 takes `ser_in`, and cell i takes the old value of cell i-1. `ser_out` always shows the capture stage of cell NUM_CELLS-1.
- R4: On a clock edge where `cap_en`=0, the capture stages keep their values, whatever `shift_sel`, `ser_in` and `par_in` are.
- R5: On a clock edge where `upd_en`=1, each update stage copies its own capture stage. When `upd_en`=0, the update stages hold.
- R6: When `test_mode`=0, `par_out` equals `par_in` combinationally, with no clock edge in the path.
- R7: When `test_mode`=1, `par_out` equals the update stages. Shifting or capturing without `upd_en` leaves `par_out` unchanged.
- R8: A bit placed on `ser_in` appears on `ser_out` after exactly NUM_CELLS shift edges, and not before.
- R9: When `cap_en` and `upd_en` are both high on the same edge, the update stages take the capture values from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock for both stages |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_sel | input | 1 | 1 selects the serial path, 0 selects the parallel load |
| cap_en | input | 1 | Enable strobe for the capture/shift stage |
| upd_en | input | 1 | Enable strobe for the update stage |
| test_mode | input | 1 | 1 drives the update stages onto `par_out`, 0 passes `par_in` through |
| ser_in | input | 1 | Serial input into cell 0 |
| par_in | input | NUM_CELLS | Parallel inputs, one bit per cell |
| par_out | output | NUM_CELLS | Parallel outputs, one bit per cell |
| ser_out | output | 1 | Serial output from the last cell |

## Verification
The bench builds two chains side by side on the same control inputs. One chain has five cells, so a walking bit can be seen to arrive at `ser_out` on the fifth shift edge and not earlier, and shift, capture and update can be mixed across the cells. The other chain has a single cell. In that chain the serial input feeds the output stage directly, which is the degenerate edge of the shift path. Random control mixes on both chains also reach the case where the capture and update strobes fire on the same edge.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
   typedef enum logic {
      SRC_PARALLEL = 1'b0,
      SRC_SERIAL   = 1'b1
   } src_sel_e;

   localparam logic STAGE_RESET = 1'b0;
endpackage

// File: rtl/bsc_shift_stage.sv
module bsc_shift_stage
   import bsc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  src_sel_e src,
   input  logic     par_d,
   input  logic     ser_d,
   output logic     q
);
   logic nxt;

   always_comb begin
      nxt = (src == SRC_SERIAL) ? ser_d : par_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= STAGE_RESET;
      else if (en)
         q <= nxt;
   end
endmodule

// File: rtl/bsc_update_stage.sv
module bsc_update_stage
   import bsc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= STAGE_RESET;
      else if (en)
         q <= d;
   end
endmodule

// File: rtl/bsc_cell.sv
module bsc_cell
   import bsc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic shift_sel,
   input  logic cap_en,
   input  logic upd_en,
   input  logic test_mode,
   input  logic sys_in,
   input  logic chain_in,
   output logic sys_out,
   output logic chain_out,
   output logic upd_state
);
   logic     cap_q;
   logic     upd_q;
   src_sel_e src;

   assign src = shift_sel ? SRC_SERIAL : SRC_PARALLEL;

   bsc_shift_stage u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cap_en),
      .src   (src),
      .par_d (sys_in),
      .ser_d (chain_in),
      .q     (cap_q)
   );

   bsc_update_stage u_upd (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (upd_en),
      .d     (cap_q),
      .q     (upd_q)
   );

   assign sys_out   = test_mode ? upd_q : sys_in;
   assign chain_out = cap_q;
   assign upd_state = upd_q;
endmodule

// File: rtl/bsc_chain.sv
module bsc_chain #(
   parameter int NUM_CELLS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 shift_sel,
   input  logic                 cap_en,
   input  logic                 upd_en,
   input  logic                 test_mode,
   input  logic                 ser_in,
   input  logic [NUM_CELLS-1:0] par_in,
   output logic [NUM_CELLS-1:0] par_out,
   output logic                 ser_out
);
   localparam int LAST = NUM_CELLS - 1;

   if (NUM_CELLS < 1) begin : g_bad_count
      $error("bsc_chain: NUM_CELLS must be at least 1");
   end

   logic [NUM_CELLS:0]   link;
   logic [NUM_CELLS-1:0] cap_q;
   logic [NUM_CELLS-1:0] upd_q;

   assign link[0] = ser_in;

   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
      bsc_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .shift_sel (shift_sel),
         .cap_en    (cap_en),
         .upd_en    (upd_en),
         .test_mode (test_mode),
         .sys_in    (par_in[i]),
         .chain_in  (link[i]),
         .sys_out   (par_out[i]),
         .chain_out (link[i+1]),
         .upd_state (upd_q[i])
      );
      assign cap_q[i] = link[i+1];
   end

   assign ser_out = link[LAST+1];
endmodule

// File: rtl/bsc_chain_chk.sv
module bsc_chain_chk #(
   parameter int NUM_CELLS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 shift_sel,
   input logic                 cap_en,
   input logic                 upd_en,
   input logic                 test_mode,
   input logic                 ser_in,
   input logic [NUM_CELLS-1:0] par_in,
   input logic [NUM_CELLS-1:0] par_out,
   input logic                 ser_out,
   input logic [NUM_CELLS-1:0] cap_q,
   input logic [NUM_CELLS-1:0] upd_q
);
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && !shift_sel) |=> (cap_q == $past(par_in)));

   if (NUM_CELLS > 1) begin : g_multi
      p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_en && shift_sel) |=>
            (cap_q == {$past(cap_q[NUM_CELLS-2:0]), $past(ser_in)}));
   end else begin : g_single
      p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_en && shift_sel) |=> (ser_out == $past(ser_in)));
   end

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(cap_q));

   p_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> (upd_q == $past(cap_q)));

   p_upd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(upd_q));

   p_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !test_mode |-> (par_out == par_in));

   p_test_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && !upd_en) |=> (!test_mode || $stable(par_out)));
endmodule

bind bsc_chain bsc_chain_chk #(.NUM_CELLS(NUM_CELLS)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .shift_sel (shift_sel),
   .cap_en    (cap_en),
   .upd_en    (upd_en),
   .test_mode (test_mode),
   .ser_in    (ser_in),
   .par_in    (par_in),
   .par_out   (par_out),
   .ser_out   (ser_out),
   .cap_q     (cap_q),
   .upd_q     (upd_q)
);

// File: tb/test_bsc_chain.sv
`timescale 1ns/1ps
module test_bsc_chain;
   localparam int N = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         shift_sel = 1'b0, cap_en = 1'b0, upd_en = 1'b0, test_mode = 1'b0;
   logic         ser_in = 1'b0, ser_in1 = 1'b0;
   logic [N-1:0] par_in = '0;
   logic [0:0]   par_in1 = '0;
   logic [N-1:0] par_out;
   logic [0:0]   par_out1;
   logic         ser_out, ser_out1;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [N-1:0] m_cap = '0, m_upd = '0;
   logic         m_cap1 = 1'b0, m_upd1 = 1'b0;

   always #2.5 clk = ~clk;

   bsc_chain #(.NUM_CELLS(N)) i_bsc_chain (
      .clk(clk), .rst_n(rst_n), .shift_sel(shift_sel), .cap_en(cap_en),
      .upd_en(upd_en), .test_mode(test_mode), .ser_in(ser_in),
      .par_in(par_in), .par_out(par_out), .ser_out(ser_out));

   bsc_chain #(.NUM_CELLS(1)) i_bsc_chain_one (
      .clk(clk), .rst_n(rst_n), .shift_sel(shift_sel), .cap_en(cap_en),
      .upd_en(upd_en), .test_mode(test_mode), .ser_in(ser_in1),
      .par_in(par_in1), .par_out(par_out1), .ser_out(ser_out1));

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [N-1:0] exp_out(input logic [N-1:0] upd, input logic [N-1:0] pin,
                                            input logic tm);
      return tm ? upd : pin;
   endfunction

   // One clock: inputs are already driven; advance the models at the edge and check after it.
   task automatic step(input string req);
      logic [N-1:0] nc, nu;
      logic         nc1, nu1;
      @(posedge clk);
      nc  = cap_en ? (shift_sel ? {m_cap[N-2:0], ser_in} : par_in) : m_cap;
      nu  = upd_en ? m_cap : m_upd;
      nc1 = cap_en ? (shift_sel ? ser_in1 : par_in1[0]) : m_cap1;
      nu1 = upd_en ? m_cap1 : m_upd1;
      m_cap = nc; m_upd = nu; m_cap1 = nc1; m_upd1 = nu1;
      #1;
      check({req, " ser_out"}, N'(ser_out), N'(m_cap[N-1]));
      check({req, " par_out"}, par_out, exp_out(m_upd, par_in, test_mode));
      check({req, " single ser_out"}, N'(ser_out1), N'(m_cap1));
      check({req, " single par_out"}, N'(par_out1), N'(test_mode ? m_upd1 : par_in1[0]));
      @(negedge clk);
   endtask

   task automatic drive(input logic ss, input logic ce, input logic ue, input logic tm,
                        input logic si, input logic [N-1:0] pi);
      shift_sel = ss; cap_en = ce; upd_en = ue; test_mode = tm;
      ser_in = si; par_in = pi; ser_in1 = ~si; par_in1 = pi[0];
   endtask

   initial begin
      logic [N-1:0] held;
      void'($urandom(32'd20240611));
      #12;
      // R1: reset state seen with test routing selected
      test_mode = 1'b1;
      #1;
      check("R1 reset par_out", par_out, '0);
      check("R1 reset ser_out", N'(ser_out), '0);
      check("R1 reset single", N'({par_out1[0] | ser_out1}), '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: normal mode is combinational pass-through
      drive(0, 0, 0, 0, 0, 5'b10110);
      #1 check("R6 passthrough", par_out, 5'b10110);
      par_in = 5'b01001;
      #1 check("R6 passthrough change", par_out, 5'b01001);

      // R2 then R5: parallel capture, then update and drive in test mode
      drive(0, 1, 0, 0, 0, 5'b10011);
      step("R2 capture");
      drive(0, 0, 1, 1, 0, 5'b00000);
      step("R5 update");
      check("R5 par_out after update", par_out, 5'b10011);

      // R7: shifting in test mode leaves par_out untouched
      held = par_out;
      for (int k = 0; k < 3; k++) begin
         drive(1, 1, 0, 1, k[0], 5'b11111);
         step("R7 shift under test");
         check("R7 par_out held", par_out, held);
      end

      // R4: no capture strobe, other inputs toggling
      held = m_cap;
      for (int k = 0; k < 3; k++) begin
         drive(k[0], 0, 0, 1, 1'b1, 5'b10101 ^ N'(k));
         step("R4 hold");
      end
      check("R4 ser_out unchanged", N'(ser_out), N'(held[N-1]));

      // R8: clear chain, then walk a single 1 through it
      for (int k = 0; k < N; k++) begin
         drive(1, 1, 0, 0, 0, '0);
         step("R8 flush");
      end
      drive(1, 1, 0, 0, 1, '0);
      step("R8 inject");
      for (int k = 1; k < N; k++) begin
         check("R8 not yet at ser_out", N'(ser_out), '0);
         drive(1, 1, 0, 0, 0, '0);
         step("R8 walk");
      end
      check("R8 arrives after N shifts", N'(ser_out), N'(1));

      // R9: capture and update on the same edge
      drive(0, 1, 0, 1, 0, 5'b01101);
      step("R9 setup");
      drive(0, 1, 1, 1, 0, 5'b10010);
      step("R9 same edge");
      check("R9 update took old capture", par_out, 5'b01101);

      // R3 and mixed: constrained random traffic against the model
      for (int k = 0; k < 400; k++) begin
         logic [31:0] r;
         r = $urandom;
         drive(r[0], r[1] | r[2], r[3] & r[4], r[5] | r[6], r[7], r[12:8]);
         step("R3 random mix");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule